// File: doc/BRIEF.md
# Synchronization Cell Window Address Decoder

This block sits in front of an array of shared synchronization cells and turns each access on a storage-window bus into a cell select and an operation code. The window address carries two things at once: the access mode in bits [6:3], which tells the selected cell what to do (raw data, tag control, blocking or non-blocking empty/full queue access, blocking or non-blocking P/V counting), and the cell number in the bits above a programmable stride of 128 bytes times a power of two.

The block also holds two 64-bit window configuration words, reached over a separate register bus, and a global control register reached through mode 15 of the storage window. The control register gathers sticky error flags and a stride field. Accesses narrower than a 32-bit word never reach a cell: they raise an error flag and return a bus error. Cell selects and the mode code are combinational from the request; the response comes one clock later.

Top module: `cellwin_decoder`

## Requirements
- R1: The access mode is st_addr[6:3]. Codes 0 to 5 assert cell_en with cell_view equal to the code; code 15 and codes 6 to 14 never assert cell_en or any cell_sel bit.
- R2: The cell index is st_addr shifted right by 7 plus a 3-bit grain. With GRAIN_FROM_CTRL = 0 the grain is configuration word 1 bits [2:0]; with GRAIN_FROM_CTRL = 1 it is control register bits [10:8].
- R3: A shifted index at or beyond NUM_CELLS selects cell NUM_CELLS-1; cell_sel is one-hot on cell_idx while cell_en is high, otherwise zero.
- R4: An access with st_size 0 (1 byte) or 1 (2 bytes) asserts no cell_en, answers with st_resp_err = 1 and sets control register bit 2.
- R5: A word write in mode 15 clears each control bit [2:0] whose data bit is 1, leaves the others, and replaces bits [10:8] with data [10:8]; a word read in mode 15 returns the control register.
- R6: A write to configuration word 0 changes only bits [31:10] and bit 0; a write to word 1 changes only bits [16:10] and [2:0]; every other bit keeps its value.
- R7: cfg_word selects the configuration word (address bits above bit 2); indices other than 0 and 1 read as zero and writes to them change nothing.
- R8: After reset, word 0 is zero, word 1 is 0xC00 with NUM_CELLS placed at bit 20, and the control register holds NUM_CELLS at bit 16.
- R9: st_resp_valid follows st_valid one cycle later; the read data is cell_rdata for modes 0 to 5, the control register for mode 15, all ones for modes 6 to 14, and zero on an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | CFG_IW | Configuration word index |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Configuration read data, registered |
| st_valid | input | 1 | Storage-window request |
| st_write | input | 1 | 1 write, 0 read |
| st_addr | input | ADDR_W | Window byte offset |
| st_size | input | 2 | 0 1B, 1 2B, 2 4B, 3 8B |
| st_wdata | input | 64 | Write data |
| st_resp_valid | output | 1 | Response strobe |
| st_resp_err | output | 1 | Bus error |
| st_rdata | output | 64 | Read data |
| cell_en | output | 1 | Cell operation request |
| cell_write | output | 1 | Cell operation is a write |
| cell_view | output | 4 | Operation code for the cell |
| cell_idx | output | IDX_W | Selected cell number |
| cell_sel | output | NUM_CELLS | One-hot cell select |
| cell_wdata | output | 64 | Write data to the cells |
| cell_rdata | input | 64 | Read data from the selected cell |

## Verification
The assertions watch every cycle that narrow accesses and non-cell modes never reach a cell, that selects stay one-hot and in range, that every request gets exactly one response a cycle later with the error flag on narrow accesses, and that unimplemented configuration indices read zero. The exact cell number at each stride, the grain source chosen by the parameter, the masking of configuration writes and the write-one-to-clear behaviour of the control register are shown only by the bench's sweeps over all grains, cell numbers and modes.

// File: rtl/cellwin_decoder.sv
module cellwin_decoder #(
  parameter int NUM_CELLS       = 32,
  parameter int ADDR_W          = 32,
  parameter int CFG_IW          = 3,
  parameter int GRAIN_FROM_CTRL = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_IW-1:0]    cfg_word,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [63:0]          cfg_wdata,
  output logic [63:0]          cfg_rdata,
  input  logic                 st_valid,
  input  logic                 st_write,
  input  logic [ADDR_W-1:0]    st_addr,
  input  logic [1:0]           st_size,
  input  logic [63:0]          st_wdata,
  output logic                 st_resp_valid,
  output logic                 st_resp_err,
  output logic [63:0]          st_rdata,
  output logic                 cell_en,
  output logic                 cell_write,
  output logic [3:0]           cell_view,
  output logic [((NUM_CELLS>1)?$clog2(NUM_CELLS):1)-1:0] cell_idx,
  output logic [NUM_CELLS-1:0] cell_sel,
  output logic [63:0]          cell_wdata,
  input  logic [63:0]          cell_rdata
);
  localparam int IDX_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;
  localparam logic [63:0] CNT        = 64'(NUM_CELLS);
  localparam logic [63:0] W0_KEEP    = 64'hFFFF_FC01;
  localparam logic [63:0] W1_KEEP    = 64'h0001_FC07;
  localparam logic [63:0] W1_RST     = (64'hFFF & 64'h0001_FC00) | (CNT << 20);
  localparam logic [63:0] CTRL_RST   = CNT << 16;
  localparam logic [63:0] ERR_BITS   = 64'h7;
  localparam logic [63:0] GRAIN_BITS = 64'h700;

  logic [63:0] cfg0_q, cfg1_q, ctrl_q;
  logic [2:0]  grain;
  logic        word_ok, narrow, ctrl_hit;
  logic [ADDR_W-1:0] raw_idx;

  assign cell_view  = st_addr[6:3];
  assign word_ok    = st_size >= 2'd2;
  assign narrow     = st_valid && !word_ok;
  assign cell_en    = st_valid && word_ok && (cell_view <= 4'd5);
  assign ctrl_hit   = st_valid && word_ok && (cell_view == 4'd15);
  assign cell_write = st_write;
  assign cell_wdata = st_wdata;

  generate
    if (GRAIN_FROM_CTRL != 0) begin : g_ctrl_grain
      assign grain = ctrl_q[10:8];
    end else begin : g_cfg_grain
      assign grain = cfg1_q[2:0];
    end
  endgenerate

  assign raw_idx  = st_addr >> (4'd7 + {1'b0, grain});
  assign cell_idx = (raw_idx >= ADDR_W'(NUM_CELLS)) ? IDX_W'(NUM_CELLS - 1)
                                                     : raw_idx[IDX_W-1:0];

  generate
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_sel
      assign cell_sel[i] = cell_en && (cell_idx == IDX_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (narrow) begin
      ctrl_q[2] <= 1'b1;
    end else if (ctrl_hit && st_write) begin
      ctrl_q <= (ctrl_q & ~(st_wdata & ERR_BITS) & ~GRAIN_BITS) | (st_wdata & GRAIN_BITS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= W1_RST;
    end else if (cfg_wr) begin
      if (cfg_word == CFG_IW'(0)) cfg0_q <= (cfg_wdata & W0_KEEP) | (cfg0_q & ~W0_KEEP);
      if (cfg_word == CFG_IW'(1)) cfg1_q <= (cfg_wdata & W1_KEEP) | (cfg1_q & ~W1_KEEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      case (cfg_word)
        CFG_IW'(0): cfg_rdata <= cfg0_q;
        CFG_IW'(1): cfg_rdata <= cfg1_q;
        default:    cfg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_resp_valid <= 1'b0;
      st_resp_err   <= 1'b0;
      st_rdata      <= '0;
    end else begin
      st_resp_valid <= st_valid;
      st_resp_err   <= narrow;
      if (narrow)        st_rdata <= '0;
      else if (cell_en)  st_rdata <= cell_rdata;
      else if (ctrl_hit) st_rdata <= ctrl_q;
      else               st_rdata <= '1;
    end
  end
endmodule

// File: rtl/cellwin_decoder_chk.sv
module cellwin_decoder_chk #(
  parameter int NUM_CELLS = 32,
  parameter int ADDR_W    = 32,
  parameter int CFG_IW    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CFG_IW-1:0]    cfg_word,
  input logic                 cfg_rd,
  input logic [63:0]          cfg_rdata,
  input logic                 st_valid,
  input logic [ADDR_W-1:0]    st_addr,
  input logic [1:0]           st_size,
  input logic                 st_resp_valid,
  input logic                 st_resp_err,
  input logic                 cell_en,
  input logic [3:0]           cell_view,
  input logic [((NUM_CELLS>1)?$clog2(NUM_CELLS):1)-1:0] cell_idx,
  input logic [NUM_CELLS-1:0] cell_sel
);
  a_r4_narrow_no_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_size < 2'd2) |-> (!cell_en && cell_sel == '0));
  a_r4_narrow_err: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_size < 2'd2) |=> (st_resp_valid && st_resp_err));
  a_r1_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_addr[6:3] > 4'd5) |-> (!cell_en && cell_sel == '0));
  a_r1_view_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en |-> (cell_view == st_addr[6:3]));
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en |-> ($onehot0(cell_sel) && $countones(cell_sel) == 1));
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en |-> (int'(cell_idx) < NUM_CELLS));
  a_r9_resp_once: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> st_resp_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !st_resp_valid);
  a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_word > CFG_IW'(1)) |=> (cfg_rdata == 64'd0));
endmodule

bind cellwin_decoder cellwin_decoder_chk #(
  .NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W), .CFG_IW(CFG_IW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_rd(cfg_rd),
  .cfg_rdata(cfg_rdata), .st_valid(st_valid), .st_addr(st_addr),
  .st_size(st_size), .st_resp_valid(st_resp_valid), .st_resp_err(st_resp_err),
  .cell_en(cell_en), .cell_view(cell_view), .cell_idx(cell_idx), .cell_sel(cell_sel)
);

// File: tb/cellwin_decoder_tb_top.sv
module cellwin_decoder_tb_top;
  localparam int NC = 6;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]  cfg_word = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata, cfg_rdata_c;
  logic        st_valid = 1'b0, st_write = 1'b0;
  logic [31:0] st_addr = '0;
  logic [1:0]  st_size = 2'd3;
  logic [63:0] st_wdata = '0;
  logic        rv, re, rv_c, re_c;
  logic [63:0] rd, rd_c;
  logic        cen, cen_c, cw, cw_c;
  logic [3:0]  cview, cview_c;
  logic [IW-1:0] cidx, cidx_c;
  logic [NC-1:0] csel, csel_c;
  logic [63:0] cwd, cwd_c;
  logic [63:0] crd;

  assign crd = 64'hC0DE_0000_0000_0000 | {32'd0, st_addr};

  cellwin_decoder #(.NUM_CELLS(NC), .GRAIN_FROM_CTRL(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .st_valid(st_valid), .st_write(st_write),
    .st_addr(st_addr), .st_size(st_size), .st_wdata(st_wdata), .st_resp_valid(rv),
    .st_resp_err(re), .st_rdata(rd), .cell_en(cen), .cell_write(cw), .cell_view(cview),
    .cell_idx(cidx), .cell_sel(csel), .cell_wdata(cwd), .cell_rdata(crd));

  cellwin_decoder #(.NUM_CELLS(NC), .GRAIN_FROM_CTRL(1)) dut_c (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_c), .st_valid(st_valid), .st_write(st_write),
    .st_addr(st_addr), .st_size(st_size), .st_wdata(st_wdata), .st_resp_valid(rv_c),
    .st_resp_err(re_c), .st_rdata(rd_c), .cell_en(cen_c), .cell_write(cw_c), .cell_view(cview_c),
    .cell_idx(cidx_c), .cell_sel(csel_c), .cell_wdata(cwd_c), .cell_rdata(crd));

  int compared = 0, mismatched = 0;
  logic [63:0] exp_w0, exp_w1, exp_ctrl;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_w(input int idx, input logic [63:0] d);
    @(negedge clk);
    cfg_word = 3'(idx); cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_r(input int idx, output logic [63:0] d);
    @(negedge clk);
    cfg_word = 3'(idx); cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic st_acc(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [63:0] d, output logic [63:0] r, output logic err);
    @(negedge clk);
    st_valid = 1'b1; st_write = wr; st_addr = a; st_size = sz; st_wdata = d;
    @(negedge clk);
    st_valid = 1'b0; st_write = 1'b0; st_size = 2'd3;
    r = rd; err = re;
  endtask

  function automatic logic [63:0] clampi(input logic [31:0] a, input int g);
    logic [31:0] s = a >> (7 + g);
    return (s >= 32'(NC)) ? 64'(NC - 1) : 64'(s);
  endfunction

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] r;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_w0 = 64'd0;
    exp_w1 = 64'hC00 | (64'(NC) << 20);
    exp_ctrl = 64'(NC) << 16;

    cfg_r(0, r); check("R8 word0 reset", r, exp_w0);
    cfg_r(1, r); check("R8 word1 reset", r, exp_w1);
    st_acc(1'b0, 32'h78, 2'd3, 64'd0, r, e); check("R8 ctrl reset", r, exp_ctrl);
    check("R9 ctrl read no err", 64'(e), 64'd0);

    cfg_w(0, '1); exp_w0 = 64'hFFFF_FC01;
    cfg_r(0, r); check("R6 word0 mask", r, exp_w0);
    cfg_w(0, 64'h1234_5678_9ABC_DEF0); exp_w0 = (64'h9ABC_DEF0 & 64'hFFFF_FC01);
    cfg_r(0, r); check("R6 word0 keep", r, exp_w0);
    cfg_w(1, '1); exp_w1 = exp_w1 | 64'h1_FC07;
    cfg_r(1, r); check("R6 word1 mask", r, exp_w1);
    cfg_w(1, 64'hFFFF_FFFF_FFF0_0000); exp_w1 = exp_w1 & ~64'h1_FC07;
    cfg_r(1, r); check("R6 word1 keep high", r, exp_w1);

    for (int k = 2; k < 8; k++) begin
      cfg_w(k, '1);
      cfg_r(k, r); check("R7 unimpl read zero", r, 64'd0);
    end
    cfg_r(0, r); check("R7 word0 untouched", r, exp_w0);
    cfg_r(1, r); check("R7 word1 untouched", r, exp_w1);

    for (int g = 0; g < 8; g++) begin
      exp_w1 = (exp_w1 & ~64'h1_FC07) | 64'(g);
      cfg_w(1, 64'(g));
      st_acc(1'b1, 32'h78, 2'd3, 64'((7 - g) << 8), r, e);
      exp_ctrl = (exp_ctrl & ~64'h700) | 64'((7 - g) << 8);
      for (int c = 0; c < 10; c++) begin
        for (int v = 0; v < 16; v++) begin
          logic [31:0] a;
          logic [63:0] er;
          a = (32'(c) << (7 + g)) | (32'(v) << 3) | 32'h5;
          if (g > 0) a = a | (32'd1 << (6 + g));
          @(negedge clk);
          st_valid = 1'b1; st_write = 1'b0; st_addr = a; st_size = 2'd3;
          #1;
          check("R1 cell_en by mode", 64'(cen), 64'(v <= 5));
          check("R1 cell_en mode ctrl-grain", 64'(cen_c), 64'(v <= 5));
          if (v <= 5) begin
            check("R1 view code", 64'(cview), 64'(v));
            check("R2 R3 index cfg grain", 64'(cidx), clampi(a, g));
            check("R2 R3 index ctrl grain", 64'(cidx_c), clampi(a, 7 - g));
            check("R3 one-hot select", 64'(csel), 64'(1) << clampi(a, g));
          end else begin
            check("R1 no select", 64'(csel), 64'd0);
          end
          er = (v <= 5) ? (64'hC0DE_0000_0000_0000 | 64'(a)) : (v == 15) ? exp_ctrl : '1;
          @(negedge clk);
          st_valid = 1'b0;
          check("R9 resp valid", 64'(rv), 64'd1);
          check("R9 read data", rd, er);
        end
      end
    end

    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h90; st_size = 2'd0;
    #1; check("R4 byte no cell", {63'd0, cen}, 64'd0);
    st_size = 2'd1;
    #1; check("R4 half no cell", {63'd0, cen}, 64'd0);
    @(negedge clk);
    st_valid = 1'b0; st_size = 2'd3;
    check("R4 error response", 64'(re), 64'd1);
    check("R9 error data zero", rd, 64'd0);
    exp_ctrl = exp_ctrl | 64'h4;
    st_acc(1'b0, 32'h78, 2'd3, 64'd0, r, e); check("R4 ctrl bit2 set", r, exp_ctrl);
    st_acc(1'b1, 32'h78, 2'd3, 64'h3 | (exp_ctrl & 64'h700), r, e);
    st_acc(1'b0, 32'h78, 2'd3, 64'd0, r, e); check("R5 write 0 keeps bit2", r, exp_ctrl);
    st_acc(1'b1, 32'h78, 2'd3, 64'h204, r, e);
    exp_ctrl = (exp_ctrl & ~64'h704) | 64'h200;
    st_acc(1'b0, 32'h78, 2'd3, 64'd0, r, e); check("R5 w1c and grain", r, exp_ctrl);
    st_acc(1'b0, 32'h10, 2'd2, 64'd0, r, e); check("R9 word size ok", 64'(e), 64'd0);

    @(negedge clk);
    check("R9 idle no resp", 64'(rv), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule